// File: doc/BRIEF.md
# Transceiver Lane Reconfiguration Sequencer

This block carries out the reconfiguration of one transceiver lane once an upstream arbiter has granted that lane a request. It takes the requested lane number and a configuration mode, and raises an acknowledge/busy flag that stays high for the whole job. It waits until the reconfiguration controller is idle and the reset controller reports both transmit and receive ready. It then writes the lane number to the controller and streams the configuration image held for the requested mode, one word per cycle.

After streaming, the sequencer watches the controller's busy line. The line must rise and then fall before the work counts as finished. The sequencer then pulses the digital reset of the reconfigured lane for a fixed number of cycles and waits for the link to come up. The job ends with a one-cycle done pulse in the same cycle that acknowledge/busy drops, which frees the arbiter for the next request. If the busy line never rises, or the link never comes up, a timeout ends the job and an error flag is raised.

Top module: `lane_reconf_seq`

## Requirements
- R1: After reset, ackBusy, done, errFlag, imgValid, chanWrite and every bit of digReset are 0.
- R2: A reqValid sampled high while the block is idle is accepted, and ackBusy is 1 from the next cycle until the done cycle. A reqValid that arrives while a job is running is ignored: chanSel keeps the lane of the running job.
- R3: chanWrite pulses for one cycle with chanSel equal to the requested lane. It does so only in the cycle after a cycle in which ctrlBusy was 0 and both txReady and rxReady were 1. While that condition is unmet, chanWrite stays 0.
- R4: Starting the cycle after chanWrite, image m (m = reqMode, 0..3) is output one word per cycle on imgData with imgValid high. The image has BASE_LEN+m words (3+m by default). Word i is {4'hA, 4-bit m, 8-bit i}. The terminating all-ones marker word is never presented with imgValid.
- R5: No digReset bit rises until ctrlBusy has been seen high and then low after the image was streamed.
- R6: digReset[lane] is 1 for exactly RST_CYCLES consecutive cycles (8 by default), starting the cycle after ctrlBusy is sampled low. All other digReset bits stay 0.
- R7: After the reset pulse the block waits for linkReady. done is 1 for exactly one cycle, the cycle after linkReady is sampled high, and ackBusy is 0 in that cycle.
- R8: If ctrlBusy does not rise within TIMEOUT cycles after streaming, done pulses with errFlag 1 and no reset pulse is given. The same happens if linkReady does not arrive within TIMEOUT cycles after the reset pulse. errFlag holds until the next request is accepted and is 0 after a job that completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Granted reconfiguration request |
| reqChannel | input | CH_W | Lane to reconfigure |
| reqMode | input | MODE_W | Selects the configuration image |
| ctrlBusy | input | 1 | Reconfiguration controller busy |
| txReady | input | 1 | Transmit side ready from reset controller |
| rxReady | input | 1 | Receive side ready from reset controller |
| linkReady | input | 1 | Link up indication for the lane |
| ackBusy | output | 1 | Request acknowledged, job in progress |
| chanSel | output | CH_W | Lane number written to the controller |
| chanWrite | output | 1 | Strobe that writes chanSel |
| imgValid | output | 1 | imgData carries an image word |
| imgData | output | 16 | Configuration image word |
| digReset | output | NUM_CH | Per-lane digital reset |
| done | output | 1 | One-cycle end-of-job pulse |
| errFlag | output | 1 | Last job ended by timeout |

## Verification
A wrong state register shows up first in the cycle-exact strobes. A missed ready gate produces an early chanWrite. A skipped busy phase produces a reset pulse before ctrlBusy has been high. A corrupted address or mode register produces a mismatching imgData word, or a stray or missing word, within one cycle of streaming. A counter fault changes the length of the reset pulse or makes done arrive without errFlag, and each of these is visible within a few cycles of the phase where it occurs.

// File: rtl/lane_reconf_pkg.sv
package lane_reconf_pkg;

  localparam int IMG_W = 16;
  localparam logic [IMG_W-1:0] END_MARK = '1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT_READY, ST_SET_CH, ST_STREAM, ST_WAIT_BUSY_HI,
    ST_WAIT_BUSY_LO, ST_RESET, ST_WAIT_LINK, ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic incAddr;
    logic rstOn;
    logic setErr;
    logic cntClr;
  } seqStrobe_t;

  // image m holds baseLen+m words, then the end marker
  function automatic logic [IMG_W-1:0] imgWord(int img, int idx, int baseLen);
    logic [3:0] imgField;
    logic [7:0] idxField;
    imgField = img[3:0];
    idxField = idx[7:0];
    if (idx < baseLen + img) return {4'hA, imgField, idxField};
    return END_MARK;
  endfunction

endpackage

// File: rtl/lane_reconf_ctl.sv
module lane_reconf_ctl
  import lane_reconf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       ctrlBusy,
  input  logic       txReady,
  input  logic       rxReady,
  input  logic       linkReady,
  input  logic       isEnd,
  input  logic       rstLast,
  input  logic       tmoHit,
  output seqStrobe_t strb,
  output logic       ackBusy,
  output logic       chanWrite,
  output logic       imgValid,
  output logic       done
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    strb.latchReq = 1'b0;
    strb.incAddr  = 1'b0;
    strb.setErr   = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        nextState     = ST_WAIT_READY;
        strb.latchReq = 1'b1;
      end
      ST_WAIT_READY: if (!ctrlBusy && txReady && rxReady) nextState = ST_SET_CH;
      ST_SET_CH: nextState = ST_STREAM;
      ST_STREAM: begin
        if (isEnd) nextState = ST_WAIT_BUSY_HI;
        else       strb.incAddr = 1'b1;
      end
      ST_WAIT_BUSY_HI: begin
        if (ctrlBusy) nextState = ST_WAIT_BUSY_LO;
        else if (tmoHit) begin
          nextState   = ST_DONE;
          strb.setErr = 1'b1;
        end
      end
      ST_WAIT_BUSY_LO: if (!ctrlBusy) nextState = ST_RESET;
      ST_RESET: if (rstLast) nextState = ST_WAIT_LINK;
      ST_WAIT_LINK: begin
        if (linkReady) nextState = ST_DONE;
        else if (tmoHit) begin
          nextState   = ST_DONE;
          strb.setErr = 1'b1;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
    strb.cntClr = (nextState != state);
    strb.rstOn  = (state == ST_RESET);
  end

  assign ackBusy   = (state != ST_IDLE) && (state != ST_DONE);
  assign chanWrite = (state == ST_SET_CH);
  assign imgValid  = (state == ST_STREAM) && !isEnd;
  assign done      = (state == ST_DONE);

  AST_CHWR_READY: assert property (@(posedge clk) disable iff (!rstN)
    chanWrite |-> $past(!ctrlBusy && txReady && rxReady)); // R3
  AST_RESET_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESET && $past(state) != ST_RESET) |-> ($past(state) == ST_WAIT_BUSY_LO && !$past(ctrlBusy))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_ACK_LOW_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ackBusy); // R7
  AST_IMG_UNDER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    imgValid |-> ackBusy); // R4

endmodule

// File: rtl/lane_reconf_dp.sv
module lane_reconf_dp
  import lane_reconf_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_IMG    = 4,
  parameter int BASE_LEN   = 3,
  parameter int RST_CYCLES = 8,
  parameter int TIMEOUT    = 4096,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int MODE_W    = $clog2(NUM_IMG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [CH_W-1:0]   reqChannel,
  input  logic [MODE_W-1:0] reqMode,
  output logic [CH_W-1:0]   chanSel,
  output logic [IMG_W-1:0]  imgData,
  output logic              isEnd,
  output logic              rstLast,
  output logic              tmoHit,
  output logic [NUM_CH-1:0] digReset,
  output logic              errFlag
);

  localparam int DEPTH   = BASE_LEN + NUM_IMG;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int CNT_MAX = (RST_CYCLES > TIMEOUT) ? RST_CYCLES : TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [IMG_W-1:0]  imgRom [NUM_IMG][DEPTH];
  logic [MODE_W-1:0] modeReg;
  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  cnt;
  logic [CH_W-1:0]   chReg;
  logic              errReg;

  for (genvar m = 0; m < NUM_IMG; m++) begin : g_img
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign imgRom[m][i] = imgWord(m, i, BASE_LEN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chReg   <= '0;
      modeReg <= '0;
      addrReg <= '0;
      errReg  <= 1'b0;
      cnt     <= '0;
    end else begin
      if (strb.latchReq) begin
        chReg   <= reqChannel;
        modeReg <= reqMode;
        addrReg <= '0;
        errReg  <= 1'b0;
      end else begin
        if (strb.incAddr) addrReg <= addrReg + 1'b1;
        if (strb.setErr)  errReg  <= 1'b1;
      end
      if (strb.cntClr)                   cnt <= '0;
      else if (cnt != CNT_W'(CNT_MAX))   cnt <= cnt + 1'b1;
    end
  end

  assign imgData  = imgRom[modeReg][addrReg];
  assign isEnd    = (imgData == END_MARK);
  assign rstLast  = (cnt == CNT_W'(RST_CYCLES - 1));
  assign tmoHit   = (cnt == CNT_W'(TIMEOUT - 1));
  assign chanSel  = chReg;
  assign errFlag  = errReg;
  assign digReset = strb.rstOn ? (NUM_CH'(1) << chReg) : '0;

  AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(digReset)); // R6
  AST_RST_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (digReset != '0) |-> digReset[chReg]); // R6
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.incAddr |-> !isEnd); // R4
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchReq |=> !errFlag); // R8

endmodule

// File: rtl/lane_reconf_seq.sv
module lane_reconf_seq
  import lane_reconf_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_IMG    = 4,
  parameter int BASE_LEN   = 3,
  parameter int RST_CYCLES = 8,
  parameter int TIMEOUT    = 4096,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int MODE_W    = $clog2(NUM_IMG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CH_W-1:0]   reqChannel,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              ctrlBusy,
  input  logic              txReady,
  input  logic              rxReady,
  input  logic              linkReady,
  output logic              ackBusy,
  output logic [CH_W-1:0]   chanSel,
  output logic              chanWrite,
  output logic              imgValid,
  output logic [IMG_W-1:0]  imgData,
  output logic [NUM_CH-1:0] digReset,
  output logic              done,
  output logic              errFlag
);

  seqStrobe_t strb;
  logic isEnd, rstLast, tmoHit;

  lane_reconf_ctl ctl_i (
    .clk, .rstN, .reqValid, .ctrlBusy, .txReady, .rxReady, .linkReady,
    .isEnd, .rstLast, .tmoHit, .strb, .ackBusy, .chanWrite, .imgValid, .done
  );

  lane_reconf_dp #(
    .NUM_CH(NUM_CH), .NUM_IMG(NUM_IMG), .BASE_LEN(BASE_LEN),
    .RST_CYCLES(RST_CYCLES), .TIMEOUT(TIMEOUT)
  ) dp_i (
    .clk, .rstN, .strb, .reqChannel, .reqMode, .chanSel, .imgData,
    .isEnd, .rstLast, .tmoHit, .digReset, .errFlag
  );

endmodule

// File: tb/lane_reconf_seq_tb_top.sv
`timescale 1ns/1ps
module lane_reconf_seq_tb_top;

  localparam int RSTC = 8;
  localparam int TMO  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqChannel = '0;
  logic [1:0] reqMode = '0;
  logic ctrlBusy = 1'b0, txReady = 1'b1, rxReady = 1'b1, linkReady = 1'b0;
  logic ackBusy, chanWrite, imgValid, done, errFlag;
  logic [1:0] chanSel;
  logic [15:0] imgData;
  logic [3:0] digReset;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [15:0] expQ [$];

  always #2.5 clk = ~clk;

  lane_reconf_seq #(.RST_CYCLES(RSTC), .TIMEOUT(TMO)) dut_i (
    .clk, .rstN, .reqValid, .reqChannel, .reqMode, .ctrlBusy, .txReady,
    .rxReady, .linkReady, .ackBusy, .chanSel, .chanWrite, .imgValid,
    .imgData, .digReset, .done, .errFlag
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // scoreboard monitor for the image stream (R4)
  always @(negedge clk) begin
    if (rstN && imgValid) begin
      if (expQ.size() == 0) chk(0, "R4 stray word", imgData, 0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(imgData == e, "R4 word", imgData, e);
      end
    end
  end

  task automatic waitDone(output bit seen, output bit rstSeen);
    seen = 0;
    rstSeen = 0;
    for (int k = 0; k < TMO + 20 && !seen; k++) begin
      tick();
      if (digReset != 0) rstSeen = 1;
      if (done) seen = 1;
    end
  endtask

  task automatic runTxn(input int ch, input int md, input bit stall,
                        input bit noBusy, input bit noLink, input bit intrude);
    bit seen, rstSeen, first;
    int cnt;
    for (int i = 0; i < 3 + md; i++) expQ.push_back({4'hA, 4'(md), 8'(i)});
    reqChannel = 2'(ch);
    reqMode = 2'(md);
    reqValid = 1;
    if (stall) txReady = 0;
    tick();
    reqValid = 0;
    chk(ackBusy == 1, "R2 ack", ackBusy, 1);
    chk(errFlag == 0, "R8 err cleared", errFlag, 0);
    if (stall) begin
      for (int k = 0; k < 4; k++) begin
        tick();
        chk(chanWrite == 0, "R3 tx not ready", chanWrite, 0);
      end
      txReady = 1;
      ctrlBusy = 1;
      for (int k = 0; k < 3; k++) begin
        tick();
        chk(chanWrite == 0, "R3 ctrl busy", chanWrite, 0);
      end
      ctrlBusy = 0;
    end
    seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      tick();
      if (chanWrite) seen = 1;
    end
    chk(seen, "R3 chanWrite", seen, 1);
    chk(chanSel == 2'(ch), "R3 chanSel", chanSel, ch);
    if (intrude) begin
      reqValid = 1;
      reqChannel = 2'(ch ^ 1);
    end
    for (int k = 0; k < 40 && expQ.size() != 0; k++) tick();
    reqValid = 0;
    chk(expQ.size() == 0, "R4 all words", expQ.size(), 0);
    tick();
    chk(imgValid == 0, "R4 marker hidden", imgValid, 0);
    if (noBusy) begin
      waitDone(seen, rstSeen);
      chk(seen, "R8 busy timeout done", seen, 1);
      chk(errFlag == 1, "R8 busy timeout err", errFlag, 1);
      chk(!rstSeen, "R5 no reset without busy", rstSeen, 0);
      tick();
      return;
    end
    ctrlBusy = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(digReset == 0, "R5 no reset while busy", digReset, 0);
    end
    ctrlBusy = 0;
    tick();
    first = (digReset != 0);
    chk(first, "R6 reset starts", digReset, 1 << ch);
    cnt = 0;
    for (int k = 0; k < 50 && digReset != 0; k++) begin
      chk(digReset == 4'(1 << ch), "R6 lane bit", digReset, 1 << ch);
      cnt++;
      tick();
    end
    chk(cnt == RSTC, "R6 pulse length", cnt, RSTC);
    if (noLink) begin
      waitDone(seen, rstSeen);
      chk(seen, "R8 link timeout done", seen, 1);
      chk(errFlag == 1, "R8 link timeout err", errFlag, 1);
      tick();
      return;
    end
    for (int k = 0; k < 2; k++) begin
      tick();
      chk(done == 0 && ackBusy == 1, "R7 wait link", done, 0);
    end
    linkReady = 1;
    tick();
    linkReady = 0;
    chk(done == 1, "R7 done", done, 1);
    chk(ackBusy == 0, "R7 ack low", ackBusy, 0);
    chk(errFlag == 0, "R8 ok no err", errFlag, 0);
    if (intrude) chk(chanSel == 2'(ch), "R2 ignored request", chanSel, ch);
    tick();
    chk(done == 0, "R7 done one cycle", done, 0);
    chk(ackBusy == 0, "R2 no extra accept", ackBusy, 0);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    chk(ackBusy == 0 && done == 0 && errFlag == 0, "R1 flags", {ackBusy, done, errFlag}, 0);
    chk(imgValid == 0 && chanWrite == 0 && digReset == 0, "R1 strobes", digReset, 0);
    runTxn(0, 0, 0, 0, 0, 0);
    runTxn(1, 1, 1, 0, 0, 0);
    runTxn(2, 2, 0, 0, 0, 1);
    runTxn(3, 3, 0, 0, 0, 0);
    runTxn(1, 2, 0, 1, 0, 0);
    runTxn(2, 1, 0, 0, 1, 0);
    runTxn(0, 3, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule